// File: doc/BRIEF.md
# Two-Level Interrupt Request Gate

This block sits between a small microcontroller's interrupt sources and its CPU core. It latches one event flag per source and decides whether an interrupt request goes to the core. Three core sources are handled directly: a timer overflow pulse, an edge on an external pin, and a change on an 8-bit port. A parameterised bank of peripheral sources is handled as a second group.

Every flag latches its event whatever the state of the enables. The request to the core is gated at two levels. A global enable covers every source. A group enable covers only the peripheral bank, and each source also has its own enable.

Software reaches the enables and flags through a small register bus. It clears a flag by writing zero to that flag's bit. The core pulses an acknowledge input when it takes the interrupt, and pulses a return input when it leaves the handler.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A flag sets on the clock edge where its event is seen, whatever the state of the source enable, the group enable and the global enable. The timer flag is bit 2 at address 0. The peripheral flag for source i is bit i at address 2.
- R2: A flag stays set until software writes a 0 to its bit. If an event arrives in the same cycle as that write, the flag stays set.
- R3: Address 0 is the core register: bit 7 global enable, bit 6 group enable, bits 5/4/3 the timer/pin/port enables, bits 2/1/0 the timer/pin/port flags. The request output is high exactly when the global enable is set and some core flag is set together with its enable.
- R4: A peripheral source raises the request only when the group enable (bit 6), its own enable (address 1, bit i) and its flag (address 2, bit i) are all set, and the global enable is set too.
- R5: While the global enable is clear, the request output stays low for every pattern of flags and enables.
- R6: Address 3 bit 0 selects the pin edge: 1 means a rising edge sets the pin flag, 0 means a falling edge does. The other edge has no effect. The pin goes through a two-flop synchronizer, so a level change made before edge k sets the flag at edge k+2 and not earlier.
- R7: The port flag sets while the synchronized port pins differ from a snapshot register. A bus read of address 4 returns the synchronized pins and loads them into the snapshot. Clearing the flag while the mismatch remains has no lasting effect.
- R8: An acknowledge pulse clears the global enable. A return pulse sets it. When both come in the same cycle, acknowledge wins.
- R9: After reset, every register reads 0 and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 8 | Watched port pins, asynchronous |
| periph_req | input | NPER | Peripheral event pulses, synchronous |
| irq_ack | input | 1 | Core takes the interrupt |
| irq_ret | input | 1 | Core returns from the handler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Two pairs of functions can fall in the same cycle. The first is a flag event and the software write that clears that flag. The second is an acknowledge and a return pulse. The bench provokes the first by pulsing the timer and a peripheral input in the very cycle its write strobe clears the flag registers, and provokes the second by pulsing acknowledge and return together. It judges each case by reading the registers back: the flag must survive and the global enable must end clear. The request gating is swept over all 256 core register values, crossed with four peripheral enable/flag patterns, against a formula computed in the bench.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CORE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PFLG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PORT  = 3'd4;

  localparam int B_GIE  = 7;
  localparam int B_PEIE = 6;
  localparam int NCORE  = 3;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    if (rise_sel) hit = lvl & ~prev_q;
    else          hit = ~lvl & prev_q;
  end
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         load,
  output logic         changed
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (load) snap_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign changed = |(pins ^ snap_q);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int NPER  = 4,
  parameter int PORTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic [PORTW-1:0]  port_pins,
  input  logic [NPER-1:0]   periph_req,
  input  logic              irq_ack,
  input  logic              irq_ret,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_req
);
  localparam int SYNCW = PORTW + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  // input synchronizers and detectors
  logic [SYNCW-1:0] sync_q;
  logic [PORTW-1:0] pins_s;
  logic             ext_s;
  logic             ext_hit;
  logic             port_diff;
  logic             edge_rise_q;
  logic             wr_core, wr_pen, wr_pflg, wr_cfg, rd_port;

  irq_sync2 #(.W(SYNCW)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({ext_pin, port_pins}), .q(sync_q)
  );
  assign ext_s  = sync_q[SYNCW-1];
  assign pins_s = sync_q[PORTW-1:0];

  irq_edge_det u_edge (
    .clk(clk), .rst_n(rst_q), .lvl(ext_s), .rise_sel(edge_rise_q), .hit(ext_hit)
  );

  irq_port_watch #(.W(PORTW)) u_watch (
    .clk(clk), .rst_n(rst_q), .pins(pins_s), .load(rd_port), .changed(port_diff)
  );

  // register decode
  assign wr_core = bus_wr && (bus_addr == A_CORE);
  assign wr_pen  = bus_wr && (bus_addr == A_PEN);
  assign wr_pflg = bus_wr && (bus_addr == A_PFLG);
  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign rd_port = bus_rd && (bus_addr == A_PORT);

  // state
  logic             gie_q, gie_d;
  logic             peie_q, peie_d;
  logic [NCORE-1:0] en_q, en_d;
  logic [NCORE-1:0] fl_q, fl_d;
  logic [NCORE-1:0] core_evt;
  logic [NPER-1:0]  pen_q, pen_d;
  logic [NPER-1:0]  pfl_q, pfl_d;
  logic             edge_rise_d;

  // core sources in bit order: timer, pin, port
  assign core_evt = {tmr_ovf, ext_hit, port_diff};

  always_comb begin
    gie_d       = gie_q;
    peie_d      = peie_q;
    en_d        = en_q;
    fl_d        = fl_q;
    pen_d       = pen_q;
    pfl_d       = pfl_q;
    edge_rise_d = edge_rise_q;

    if (wr_core) begin
      gie_d  = bus_wdata[B_GIE];
      peie_d = bus_wdata[B_PEIE];
      en_d   = bus_wdata[2*NCORE-1:NCORE];
      fl_d   = bus_wdata[NCORE-1:0];
    end
    fl_d = fl_d | core_evt;

    if (irq_ack)      gie_d = 1'b0;
    else if (irq_ret) gie_d = 1'b1;

    if (wr_pen)  pen_d = bus_wdata[NPER-1:0];
    if (wr_pflg) pfl_d = bus_wdata[NPER-1:0];
    pfl_d = pfl_d | periph_req;

    if (wr_cfg) edge_rise_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gie_q       <= 1'b0;
      peie_q      <= 1'b0;
      en_q        <= '0;
      fl_q        <= '0;
      pen_q       <= '0;
      pfl_q       <= '0;
      edge_rise_q <= 1'b0;
    end else begin
      gie_q       <= gie_d;
      peie_q      <= peie_d;
      en_q        <= en_d;
      fl_q        <= fl_d;
      pen_q       <= pen_d;
      pfl_q       <= pfl_d;
      edge_rise_q <= edge_rise_d;
    end
  end

  // readback
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CORE: bus_rdata = {gie_q, peie_q, en_q, fl_q};
      A_PEN:  bus_rdata[NPER-1:0] = pen_q;
      A_PFLG: bus_rdata[NPER-1:0] = pfl_q;
      A_CFG:  bus_rdata[0] = edge_rise_q;
      A_PORT: bus_rdata[PORTW-1:0] = pins_s;
      default: bus_rdata = '0;
    endcase
  end

  // two-level gating
  logic core_pend, grp_pend;
  assign core_pend = |(en_q & fl_q);
  assign grp_pend  = peie_q & (|(pen_q & pfl_q));
  assign irq_req   = gie_q & (core_pend | grp_pend);
endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
  parameter int NPER = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic            irq_req,
  input logic            gie_q,
  input logic            peie_q,
  input logic [2:0]      en_q,
  input logic [2:0]      fl_q,
  input logic [NPER-1:0] pfl_q,
  input logic            tmr_ovf,
  input logic [NPER-1:0] periph_req,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic            bus_wr,
  input logic [2:0]      bus_addr
);
  a_r1_tmr_flag_latches: assert property (@(posedge clk) disable iff (!rst_q)
    tmr_ovf |=> fl_q[2]);

  a_r1_periph_flag_latches: assert property (@(posedge clk) disable iff (!rst_q)
    periph_req[0] |=> pfl_q[0]);

  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (fl_q[2] && !(bus_wr && bus_addr == 3'd0)) |=> fl_q[2]);

  a_r5_gie_masks: assert property (@(posedge clk) disable iff (!rst_q)
    !gie_q |-> !irq_req);

  a_r4_group_gate: assert property (@(posedge clk) disable iff (!rst_q)
    (!peie_q && ((en_q & fl_q) == 3'b000)) |-> !irq_req);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_q)
    irq_ack |=> !gie_q);

  a_r8_ret_sets: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ret && !irq_ack) |=> gie_q);
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.NPER(NPER)) u_chk (
  .clk(clk), .rst_q(rst_q), .irq_req(irq_req), .gie_q(gie_q), .peie_q(peie_q),
  .en_q(en_q), .fl_q(fl_q), .pfl_q(pfl_q), .tmr_ovf(tmr_ovf),
  .periph_req(periph_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/irq_gate_ctrl_bench.sv
module irq_gate_ctrl_bench;
  localparam int NPER = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            tmr_ovf, ext_pin, irq_ack, irq_ret, bus_wr, bus_rd;
  logic [7:0]      port_pins, bus_wdata, bus_rdata;
  logic [NPER-1:0] periph_req;
  logic [2:0]      bus_addr;
  logic            irq_req;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  irq_gate_ctrl #(.NPER(NPER)) u_irq_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
    .port_pins(port_pins), .periph_req(periph_req), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [3:0] pen, pfl;
    logic       exp_irq;
    rst_n = 1'b0; tmr_ovf = 0; ext_pin = 0; irq_ack = 0; irq_ret = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    port_pins = 8'h00; periph_req = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v);
      check("R9 reset readback", v, 8'h00);
    end
    check("R9 reset irq", irq_req, 1'b0);

    // R3 R4 R5 sweep over all core values and peripheral patterns
    for (int p = 0; p < 4; p++) begin
      pen = p[0] ? 4'b0101 : 4'b0000;
      pfl = p[1] ? 4'b0100 : 4'b1010;
      wr(3'd1, {4'h0, pen});
      wr(3'd2, {4'h0, pfl});
      for (int m = 0; m < 256; m++) begin
        wr(3'd0, m[7:0]);
        exp_irq = m[7] & ((m[5] & m[2]) | (m[4] & m[1]) | (m[3] & m[0]) |
                          (m[6] & (|(pen & pfl))));
        if (!m[7])      check("R5 global mask", irq_req, exp_irq);
        else if (m[6])  check("R4 group gating", irq_req, exp_irq);
        else            check("R3 core gating", irq_req, exp_irq);
      end
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R1 timer flag latches with all enables off
    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    rd(3'd0, v);
    check("R1 timer flag latched", v, 8'h04);
    check("R1 no request when disabled", irq_req, 1'b0);

    // R2 clear write coinciding with timer event: flag survives
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'h00; bus_wr = 1; tmr_ovf = 1;
    @(negedge clk);
    bus_wr = 0; tmr_ovf = 0;
    rd(3'd0, v);
    check("R2 event beats clear", v, 8'h04);
    wr(3'd0, 8'h00);
    rd(3'd0, v);
    check("R2 plain clear", v, 8'h00);

    // R1 R2 peripheral flag
    @(negedge clk); periph_req = 4'b1000;
    @(negedge clk); periph_req = '0;
    idle(3);
    rd(3'd2, v);
    check("R1 periph flag latched and held", v, 8'h08);
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h00; bus_wr = 1; periph_req = 4'b0010;
    @(negedge clk);
    bus_wr = 0; periph_req = '0;
    rd(3'd2, v);
    check("R2 periph event beats clear", v, 8'h02);
    wr(3'd2, 8'h00);

    // R6 rising edge selected, with latency
    wr(3'd3, 8'h01);
    ext_pin = 1;
    idle(1);
    rd(3'd0, v);
    check("R6 not before two sync stages", v, 8'h00);
    rd(3'd0, v);
    check("R6 rising edge sets pin flag", v, 8'h02);
    wr(3'd0, 8'h00);
    ext_pin = 0;
    idle(5);
    rd(3'd0, v);
    check("R6 falling edge ignored in rising mode", v, 8'h00);
    wr(3'd3, 8'h00);
    ext_pin = 1;
    idle(5);
    rd(3'd0, v);
    check("R6 rising edge ignored in falling mode", v, 8'h00);
    ext_pin = 0;
    idle(5);
    rd(3'd0, v);
    check("R6 falling edge sets pin flag", v, 8'h02);
    wr(3'd0, 8'h00);

    // R7 port change against snapshot
    port_pins = 8'h28;
    idle(1);
    rd(3'd0, v);
    check("R7 port flag not before sync", v, 8'h00);
    rd(3'd0, v);
    check("R7 port change sets flag", v, 8'h01);
    wr(3'd0, 8'h00);
    idle(2);
    rd(3'd0, v);
    check("R7 clear without read re-sets", v, 8'h01);
    rd(3'd4, v);
    check("R7 port readback", v, 8'h28);
    wr(3'd0, 8'h00);
    idle(3);
    rd(3'd0, v);
    check("R7 clear after snapshot reload holds", v, 8'h00);

    // R8 acknowledge and return
    wr(3'd0, 8'hA4);
    check("R3 request with timer source", irq_req, 1'b1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    rd(3'd0, v);
    check("R8 ack clears global enable", v, 8'h24);
    check("R8 request dropped after ack", irq_req, 1'b0);
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
    rd(3'd0, v);
    check("R8 return sets global enable", v, 8'hA4);
    check("R8 request back after return", irq_req, 1'b1);
    @(negedge clk); irq_ack = 1; irq_ret = 1;
    @(negedge clk); irq_ack = 0; irq_ret = 0;
    rd(3'd0, v);
    check("R8 ack wins over return", v, 8'h24);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule